// File: doc/BRIEF.md
# Four-Register Bus Slave

This block is a memory-mapped slave for an AHB-Lite bus. It holds four 32-bit registers that a processor writes and reads as a small array of words. During a transfer's address phase the block records whether the transfer is a write and which register it targets. In the next cycle, the data phase, it either stores the write data into that register or presents that register's contents as read data.

The interconnect decodes only the top four address bits to select this slave. The slave itself looks only at the word-index bits `haddr[3:2]`, so the four registers repeat at every 16-byte step across the whole region it answers for. Register 0 is also brought out on a dedicated output port, so software that only writes the first word sees the same effect as with a plain output latch. Every transfer completes in one data-phase cycle with an OKAY response.

Top module: `ahb_quad_reg_slave`

## Requirements
- R1: While `hresetn` is low at a rising edge of `hclk`, all four registers, the latched write flag and the latched index are cleared. After reset, `hrdata` and `port_out` read 0.
- R2: A write transfer is captured when `hsel`=1, `hready`=1, `hwrite`=1 and `htrans[1]`=1 (NONSEQ=2'b10 or SEQ=2'b11). On the next rising edge, `hwdata` is stored into the register whose index is `haddr[3:2]` as sampled in the address phase. The other registers keep their values.
- R3: During the data phase of a read, `hrdata` shows the contents of the register chosen by `haddr[3:2]` from that read's address phase.
- R4: The register index is taken only in the address phase. Changes to `haddr` during a data phase do not alter which register `hrdata` shows or which register a write lands in.
- R5: Address bits other than `haddr[3:2]` are ignored. This includes bits [31:4], such as any base from 0x5 to 0xF in the top nibble, and bits [1:0]. Every access is treated as a full 32-bit word.
- R6: IDLE (2'b00) or BUSY (2'b01) transfers, cycles with `hsel`=0, and cycles with `hready`=0 change no register.
- R7: `port_out` always equals register 0 and follows a write to index 0 from the edge that stores it.
- R8: `hreadyout` is always 1 and `hresp` is always 0 (OKAY).
- R9: A read issued in the cycle directly after a write's address phase, to the same register, returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select from the interconnect |
| haddr | input | 32 | Transfer address; bits [3:2] pick the register |
| hwrite | input | 1 | 1 = write, 0 = read |
| htrans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| hsize | input | 3 | Transfer size; ignored, every access is a word |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready; previous transfer completing |
| hrdata | output | 32 | Read data for the data phase |
| hreadyout | output | 1 | Slave ready, tied high |
| hresp | output | 1 | Transfer response, tied to OKAY |
| port_out | output | 32 | Live copy of register 0 |

## Verification
The assertions check several rules on every cycle. No register moves without a latched write flag. A flagged write lands its data in the latched register and leaves the other three untouched. The index holds whenever no valid address phase is seen. Non-transfers never raise the write flag. A write to index 0 appears on `port_out`. Only the bench scenarios can show the end-to-end mapping from a full bus address to a register. This covers aliasing across the upper nibble and low bits, the protection of the index against data-phase address changes, the back-to-back write-then-read forwarding, and the reset clearing of contents written beforehand.

// File: rtl/ahbq_pkg.sv
// Package ahbq_pkg
// Shared bus encodings for the four-register slave.
// Assumes AHB-Lite transfer-type coding; bit 1 set marks an active transfer.
package ahbq_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic RESP_OKAY = 1'b0;

    // True when the transfer type carries data (NONSEQ or SEQ)
    function automatic logic is_active(input logic [1:0] tr);
        return tr[1];
    endfunction

endpackage

// File: rtl/quad_addr_capture.sv
// Module quad_addr_capture
// Registers the address-phase controls: a write flag and the register index.
// Assumes the index arrives already sliced from the word-address bits.
// The flag lasts exactly one data-phase cycle; the index holds until the
// next valid address phase so read data stays selected.
module quad_addr_capture #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rstn,
    input  logic             sel,
    input  logic             wr,
    input  logic [1:0]       trans,
    input  logic             rdy,
    input  logic [IDX_W-1:0] addr_idx,
    output logic             wr_flag,
    output logic [IDX_W-1:0] idx_q
);
    import ahbq_pkg::*;

    logic take_phase;

    // Valid address phase for this slave
    always_comb take_phase = sel && rdy && is_active(trans);

    // Capture write intent and word index on each completed address phase
    always_ff @(posedge clk) begin
        if (!rstn) begin
            wr_flag <= 1'b0;
            idx_q   <= '0;
        end else if (rdy) begin
            wr_flag <= take_phase && wr;
            if (take_phase) begin
                idx_q <= addr_idx;
            end
        end else begin
            wr_flag <= 1'b0;
        end
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstn)
        !take_phase |=> $stable(idx_q)) else $error("index moved"); // R4

    AST_NO_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rstn)
        (rdy && !(sel && trans[1])) |=> !wr_flag) else $error("flag set"); // R6

    AST_FLAG_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstn)
        !rdy |=> !wr_flag) else $error("flag with hready low"); // R6

endmodule

// File: rtl/quad_reg_bank.sv
// Module quad_reg_bank
// Holds NUM_REGS data registers. A latched write flag stores wdata into the
// register named by the latched index on the next edge.
// Assumes wr_flag and idx come from the address-phase capture stage.
module quad_reg_bank #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rstn,
    input  logic                             wr_flag,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic hit;

        // Decode whether this register is the write target
        always_comb hit = wr_flag && (idx == IDX_W'(g));

        // Store the data-phase write into this register
        always_ff @(posedge clk) begin
            if (!rstn) begin
                regs_q[g] <= '0;
            end else if (hit) begin
                regs_q[g] <= wdata;
            end
        end

        AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rstn)
            (wr_flag && idx != IDX_W'(g)) |=> $stable(regs_q[g]))
            else $error("untargeted register changed"); // R2
    end

    AST_NO_FLAG_STABLE: assert property (@(posedge clk) disable iff (!rstn)
        !wr_flag |=> $stable(regs_q)) else $error("register moved"); // R6

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstn)
        wr_flag |=> regs_q[$past(idx)] == $past(wdata))
        else $error("write lost"); // R2

endmodule

// File: rtl/quad_read_mux.sv
// Module quad_read_mux
// Selects read data from the register bank by the latched index.
// Purely combinational so a write committed on the previous edge is seen.
module quad_read_mux #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
    output logic [DATA_W-1:0]                rdata
);

    // Choose the register named by the latched index
    always_comb rdata = regs[idx];

endmodule

// File: rtl/ahb_quad_reg_slave.sv
// Module ahb_quad_reg_slave
// AHB-Lite slave with four word registers; register 0 mirrors to port_out.
// Assumes the interconnect drives hsel from a partial upper-address decode;
// this block looks only at the word-index bits, so registers alias widely.
// No wait states, no error responses, no byte-lane writes.
module ahb_quad_reg_slave #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int IDX_LSB = $clog2(DATA_W / 8)
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic [1:0]        htrans,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic [DATA_W-1:0] hrdata,
    output logic              hreadyout,
    output logic              hresp,
    output logic [DATA_W-1:0] port_out
);
    import ahbq_pkg::*;

    logic                            wr_flag;
    logic [IDX_W-1:0]                idx_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic                            unused_bus_bits;

    // Fold ignored address bits and size so they are visibly unused
    always_comb unused_bus_bits = ^{haddr[ADDR_W-1:IDX_LSB+IDX_W],
                                    haddr[IDX_LSB-1:0], hsize, htrans[0]};

    quad_addr_capture #(.IDX_W(IDX_W)) u_cap (
        .clk      (hclk),
        .rstn     (hresetn),
        .sel      (hsel),
        .wr       (hwrite),
        .trans    (htrans),
        .rdy      (hready),
        .addr_idx (haddr[IDX_LSB +: IDX_W]),
        .wr_flag  (wr_flag),
        .idx_q    (idx_q)
    );

    quad_reg_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk     (hclk),
        .rstn    (hresetn),
        .wr_flag (wr_flag),
        .idx     (idx_q),
        .wdata   (hwdata),
        .regs_q  (regs)
    );

    quad_read_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_mux (
        .idx   (idx_q),
        .regs  (regs),
        .rdata (hrdata)
    );

    // Fixed handshake: always ready, always OKAY
    always_comb begin
        hreadyout = 1'b1;
        hresp     = RESP_OKAY;
    end

    // Register 0 drives the external port
    always_comb port_out = regs[0];

    AST_PORT_FOLLOWS: assert property (@(posedge hclk) disable iff (!hresetn)
        (wr_flag && idx_q == '0) |=> port_out == $past(hwdata))
        else $error("port not updated"); // R7

    AST_READ_AFTER_WRITE: assert property (@(posedge hclk) disable iff (!hresetn)
        (wr_flag && hsel && hready && htrans[1] && !hwrite
         && haddr[IDX_LSB +: IDX_W] == idx_q) |=> hrdata == $past(hwdata))
        else $error("stale read after write"); // R9

endmodule

// File: tb/sim_ahb_quad_reg_slave.sv
`timescale 1ns/1ps
module sim_ahb_quad_reg_slave;

    logic        hclk = 1'b0;
    logic        hresetn = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic        hwrite = 1'b0;
    logic [1:0]  htrans = 2'b00;
    logic [2:0]  hsize = 3'b010;
    logic [31:0] hwdata = '0;
    logic        hready = 1'b1;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic        hresp;
    logic [31:0] port_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [4];

    always #2 hclk = ~hclk;

    ahb_quad_reg_slave u0 (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
        .hwrite(hwrite), .htrans(htrans), .hsize(hsize), .hwdata(hwdata),
        .hready(hready), .hrdata(hrdata), .hreadyout(hreadyout),
        .hresp(hresp), .port_out(port_out)
    );

    // Vector table: write address/data, then read address and expected value
    localparam int NV = 8;
    localparam logic [31:0] V_WA [NV] = '{32'h5000_0000, 32'h5000_0004,
        32'h5000_0008, 32'h5000_000C, 32'hF000_0010, 32'h7FFF_FFF6,
        32'h9000_003F, 32'h5000_0008};
    localparam logic [31:0] V_WD [NV] = '{32'h1111_1111, 32'h2222_2222,
        32'h3333_3333, 32'h4444_4444, 32'h5555_5555, 32'h6666_6666,
        32'h7777_7777, 32'hA5A5_A5A5};
    localparam logic [31:0] V_RA [NV] = '{32'h5000_0000, 32'h5000_0004,
        32'h5000_0000, 32'h5000_0008, 32'h5000_0000, 32'h5000_0004,
        32'h5000_000C, 32'hC000_0018};
    localparam logic [31:0] V_EX [NV] = '{32'h1111_1111, 32'h2222_2222,
        32'h1111_1111, 32'h3333_3333, 32'h5555_5555, 32'h6666_6666,
        32'h7777_7777, 32'hA5A5_A5A5};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_bus(input logic [31:0] addr);
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; haddr = addr;
    endtask

    // Single write: address phase, then data phase; returns after commit edge
    task automatic bus_write(input logic [31:0] addr, input logic [31:0] data);
        @(negedge hclk);
        hsel = 1'b1; haddr = addr; hwrite = 1'b1; htrans = 2'b10;
        @(negedge hclk);
        idle_bus(~addr);
        hwdata = data;
        @(negedge hclk);
        hwdata = 32'hDEAD_BEEF;
    endtask

    // Single read: samples hrdata mid data phase while haddr is disturbed
    task automatic bus_read(input logic [31:0] addr, output logic [31:0] data);
        @(negedge hclk);
        hsel = 1'b1; haddr = addr; hwrite = 1'b0; htrans = 2'b10;
        @(negedge hclk);
        idle_bus(addr ^ 32'h0000_000C);
        #0.5 data = hrdata;
    endtask

    task automatic read_chk(input string req, input logic [31:0] addr, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(addr, d);
        chk(req, d, exp);
    endtask

    initial begin
        repeat (100000) @(posedge hclk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        repeat (3) @(posedge hclk);
        @(negedge hclk);
        hresetn = 1'b1;
        // R1 reset state, R8 fixed handshake
        chk("R1 hrdata after reset", hrdata, 32'h0);
        chk("R1 port_out after reset", port_out, 32'h0);
        chk("R8 hreadyout", {31'h0, hreadyout}, 32'h1);
        chk("R8 hresp", {31'h0, hresp}, 32'h0);
        for (int i = 0; i < 4; i++) read_chk("R1 register cleared", 32'h5000_0000 + 32'(i * 4), 32'h0);

        // Table walk: R2 write, R3 read, R5 aliasing, R7 port mirror
        for (int v = 0; v < NV; v++) begin
            bus_write(V_WA[v], V_WD[v]);
            mdl[V_WA[v][3:2]] = V_WD[v];
            chk("R7 port_out follows reg0", port_out, mdl[0]);
            read_chk("R2 R3 R5 table readback", V_RA[v], V_EX[v]);
        end
        for (int i = 0; i < 4; i++) read_chk("R2 others kept", 32'h6000_0000 + 32'(i * 4), mdl[i]);

        // R6 IDLE and BUSY with write intent, hsel low, hready low
        @(negedge hclk);
        hsel = 1'b1; haddr = 32'h5000_0004; hwrite = 1'b1; htrans = 2'b00;
        @(negedge hclk); hwdata = 32'hBAD0_0001; htrans = 2'b01;
        @(negedge hclk); hwdata = 32'hBAD0_0002; hsel = 1'b0; htrans = 2'b10;
        @(negedge hclk); hwdata = 32'hBAD0_0003; hsel = 1'b1; hready = 1'b0;
        @(negedge hclk); hwdata = 32'hBAD0_0004; hready = 1'b1; idle_bus(32'h0);
        @(negedge hclk);
        read_chk("R6 no write on idle/busy/unselected/not-ready", 32'h5000_0004, mdl[1]);

        // R4 data-phase address change does not redirect a write
        @(negedge hclk);
        hsel = 1'b1; haddr = 32'h5000_0008; hwrite = 1'b1; htrans = 2'b10;
        @(negedge hclk);
        idle_bus(32'h5000_0000); hwdata = 32'h0BAD_CAFE;
        @(negedge hclk);
        mdl[2] = 32'h0BAD_CAFE;
        chk("R4 write not redirected to reg0", port_out, mdl[0]);
        read_chk("R4 write landed at captured index", 32'h5000_0008, 32'h0BAD_CAFE);

        // R9 back-to-back write then read of same register
        @(negedge hclk);
        hsel = 1'b1; haddr = 32'h5000_000C; hwrite = 1'b1; htrans = 2'b10;
        @(negedge hclk);
        hwdata = 32'hC0DE_0009; hwrite = 1'b0; htrans = 2'b10; haddr = 32'hE000_001C;
        @(negedge hclk);
        idle_bus(32'h0);
        #0.5 d = hrdata;
        chk("R9 read right after write", d, 32'hC0DE_0009);
        mdl[3] = 32'hC0DE_0009;

        // R1 reset in mid-run clears contents
        @(negedge hclk); hresetn = 1'b0;
        repeat (2) @(negedge hclk);
        hresetn = 1'b1;
        chk("R1 port_out after second reset", port_out, 32'h0);
        for (int i = 0; i < 4; i++) read_chk("R1 cleared by reset", 32'h5000_0000 + 32'(i * 4), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule